// File: doc/BRIEF.md
# GPIO Pin Control Cell

This cell controls a single general-purpose I/O pin. A 32-bit control word on a small register bus sets the pin direction, the output buffer type (push-pull or open-drain), the output polarity, the function select and the input pad enable. The output value comes from one of two sources: a value bit held in the control word, or this pin's bit of a parallel output word shared across pins. A disable bit in the control word picks between them. The cell drives the pad output-enable and output-data lines. It brings the pad input through a synchronizer and returns the live level on read and on a parallel-input bit.

A 4-bit detect field selects one of low level, high level, rising edge, falling edge or both edges, or turns detection off. Any event sets a sticky status bit, which is also the interrupt output. A write-once lock bit freezes the control word until the next reset. The pull, power-gate and other analog selections exist only as stored bits that read back.

Register addresses on `addr_i`:

| Address | Contents |
|---|---|
| 0 | Control word |
| 1 | Lock, bit 0 |
| 2 | Status, bit 0, cleared by writing 1 |
| 3 | Reads as zero |

Top module: `gpio_pin_cell`

## Requirements
- R1: After reset the cell reads as follows: address 0 reads 0x00008040 (detect code 0x4 is off and the input pad is disabled), the lock reads 0, the status reads 0, `irq_o` is 0 and `pad_oe_o` is 0.
- R2: Only the control bits [16:0] are writable, and they read back as written. Bits [3:0] hold the analog selections and have no other effect. Bit 24 is read-only. All other bits read 0, so writing 0xFFFFFFFF with the pad disabled reads back 0x0001FFFF.
- R3: When control bit 10 is 0, the output value is control bit 16. When bit 10 is 1, the output value is `par_out_i`.
- R4: When control bit 11 is 1, the output value is inverted before it reaches the pad.
- R5: Output-enable and function select, with bit 9 the direction (1 = output) and bit 8 the buffer type (1 = open-drain):
  - In push-pull mode, `pad_oe_o` equals bit 9.
  - In open-drain mode, `pad_oe_o` is 1 only when bit 9 is 1 and the effective output value is 0.
  - `pad_out_o` carries the effective output value.
  - `func_sel_o` equals bits [14:12].
  - Any nonzero function code forces both `pad_oe_o` and `pad_out_o` to 0.
- R6: Control bit 24 and `par_in_o` show the pad level two clock edges after `pad_in_i` changes. They read 0 while bit 15 (input pad disable) is 1.
- R7: In level modes, selected by bits [7:4] (0x0 = low, 0x1 = high), the status is set on the edge after the condition holds. While the condition persists, the status stays 1 even after a clear.
- R8: Edge modes are 0xD (rising), 0xE (falling) and 0xF (both). An edge sets the status, and `irq_o` rises three edges after the pad change. Writing 1 to bit 0 at address 2 clears the status.
- R9: Detect codes 0x4 and all codes not listed in R7 or R8 never set the status.
- R10: Changing the detect mode or the input pad enable does not create an edge event, even when the synchronized level moves in the same cycle.
- R11: Writing 1 to the lock bit sets it. After that, control writes are ignored, and writing 0 to the lock does not clear it. Only reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| par_out_i | input | 1 | This pin's bit of the parallel output word |
| par_in_o | output | 1 | Synchronized, gated pad level |
| pad_in_i | input | 1 | Pad input level, asynchronous |
| pad_oe_o | output | 1 | Pad output enable |
| pad_out_o | output | 1 | Pad output data |
| func_sel_o | output | 3 | Function select for the pin multiplexer |
| irq_o | output | 1 | Sticky interrupt status |

## Verification
Register writes take effect on the edge that samples `wr_i`, and read data and the pad outputs follow combinationally. These values are therefore due one cycle after a write is driven. The pad level reaches bit 24 and `par_in_o` two edges after `pad_in_i` moves. An edge event is due on `irq_o` one edge after that, and a level event one edge after the mode is written.

The bench drives inputs on the falling clock edge. It counts whole cycles to each due point, and it checks the cycle just before as well, to pin the latency exactly. Each check queues the value expected one time step later, so every comparison falls between active edges.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;
  localparam int unsigned CTRL_W      = 32;
  localparam logic [31:0] CTRL_RST    = 32'h0000_8040;
  localparam logic [31:0] CTRL_STORE  = 32'h0001_FFFF;
  localparam int unsigned LIVE_BIT    = 24;

  localparam int unsigned B_DET_LO  = 4;
  localparam int unsigned B_ODRAIN  = 8;
  localparam int unsigned B_DIR     = 9;
  localparam int unsigned B_SRC_PAR = 10;
  localparam int unsigned B_INV     = 11;
  localparam int unsigned B_FUNC_LO = 12;
  localparam int unsigned B_IN_OFF  = 15;
  localparam int unsigned B_VAL     = 16;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LOCK = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef enum logic [2:0] {
    DET_OFF, DET_LOW, DET_HIGH, DET_RISE, DET_FALL, DET_BOTH
  } det_kind_e;

  function automatic det_kind_e det_decode(input logic [3:0] code);
    case (code)
      4'h0:    det_decode = DET_LOW;
      4'h1:    det_decode = DET_HIGH;
      4'hD:    det_decode = DET_RISE;
      4'hE:    det_decode = DET_FALL;
      4'hF:    det_decode = DET_BOTH;
      default: det_decode = DET_OFF;
    endcase
  endfunction
endpackage

// File: rtl/gpio_cell_regs.sv
module gpio_cell_regs
  import gpio_cell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              lock_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              lock_q;
  logic              ctrl_we, lock_we;

  assign ctrl_we = wr_i && (addr_i == A_CTRL) && !lock_q;
  assign lock_we = wr_i && (addr_i == A_LOCK) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      lock_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata_i & CTRL_STORE;
      if (lock_we) lock_q <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/gpio_cell_insync.sv
module gpio_cell_insync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_cell_detect.sv
module gpio_cell_detect
  import gpio_cell_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       level_i,
  input  logic [3:0] code_i,
  input  logic       in_off_i,
  input  logic       clr_i,
  output logic       stat_o
);
  localparam logic [4:0] CFG_RST = {CTRL_RST[B_DET_LO+3:B_DET_LO], CTRL_RST[B_IN_OFF]};

  det_kind_e  kind;
  logic [4:0] cfg, cfg_q;
  logic       prev_q, stat_q;
  logic       cfg_same, rise, fall, hit;

  assign kind     = det_decode(code_i);
  assign cfg      = {code_i, in_off_i};
  assign cfg_same = (cfg == cfg_q);
  // edges are only trusted when the config matched last cycle too
  assign rise     = cfg_same && level_i && !prev_q;
  assign fall     = cfg_same && !level_i && prev_q;

  always_comb begin
    case (kind)
      DET_LOW:  hit = !level_i;
      DET_HIGH: hit = level_i;
      DET_RISE: hit = rise;
      DET_FALL: hit = fall;
      DET_BOTH: hit = rise || fall;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      cfg_q  <= cfg;
      prev_q <= level_i;
      stat_q <= (stat_q && !clr_i) || hit;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_cell_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] rdata_o,
  input  logic              par_out_i,
  output logic              par_in_o,
  input  logic              pad_in_i,
  output logic              pad_oe_o,
  output logic              pad_out_o,
  output logic [2:0]        func_sel_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              lock_q;
  logic              pad_sync, in_live;
  logic              gpio_mode, out_src, out_eff;
  logic              stat_clr;

  gpio_cell_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl_q),
    .lock_o  (lock_q)
  );

  gpio_cell_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pad_sync)
  );

  assign in_live  = pad_sync && !ctrl_q[B_IN_OFF];
  assign par_in_o = in_live;
  assign stat_clr = wr_i && (addr_i == A_STAT) && wdata_i[0];

  gpio_cell_detect u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (in_live),
    .code_i   (ctrl_q[B_DET_LO+3:B_DET_LO]),
    .in_off_i (ctrl_q[B_IN_OFF]),
    .clr_i    (stat_clr),
    .stat_o   (irq_o)
  );

  // output path
  assign func_sel_o = ctrl_q[B_FUNC_LO+2:B_FUNC_LO];
  assign gpio_mode  = (func_sel_o == 3'd0);
  assign out_src    = ctrl_q[B_SRC_PAR] ? par_out_i : ctrl_q[B_VAL];
  assign out_eff    = out_src ^ ctrl_q[B_INV];
  assign pad_out_o  = gpio_mode && out_eff;
  assign pad_oe_o   = gpio_mode && ctrl_q[B_DIR] && (!ctrl_q[B_ODRAIN] || !out_eff);

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q | (CTRL_W'(in_live) << LIVE_BIT);
      A_LOCK:  rdata_o = {{(CTRL_W-1){1'b0}}, lock_q};
      A_STAT:  rdata_o = {{(CTRL_W-1){1'b0}}, irq_o};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_cell_chk.sv
module gpio_pin_cell_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic [1:0]  addr_i,
  input logic [31:0] ctrl_q,
  input logic        lock_q,
  input logic        pad_oe_o,
  input logic        pad_out_o,
  input logic        par_in_o,
  input logic        irq_o
);
  // R11
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && wr_i && addr_i == 2'd0) |=> (ctrl_q == $past(ctrl_q)));

  // R11
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  // R5
  odrain_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[8] && pad_oe_o) |-> !pad_out_o);

  // R5
  input_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[9] |-> !pad_oe_o);

  // R6
  pad_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[15] |-> !par_in_o);

  // R7
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[7:4] == 4'h1 && par_in_o) |=> irq_o);
endmodule

bind gpio_pin_cell gpio_pin_cell_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .ctrl_q    (ctrl_q),
  .lock_q    (lock_q),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o),
  .par_in_o  (par_in_o),
  .irq_o     (irq_o)
);

// File: tb/sim_gpio_pin_cell.sv
`timescale 1ns/1ps
module sim_gpio_pin_cell;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        par_out_i = 1'b0;
  logic        par_in_o;
  logic        pad_in_i = 1'b1;
  logic        pad_oe_o, pad_out_o, irq_o;
  logic [2:0]  func_sel_o;

  localparam int P_RD = 0, P_IRQ = 1, P_OE = 2, P_OUT = 3, P_PIN = 4, P_FN = 5;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  string       tag_q[$];
  int          prb_q[$];
  logic [31:0] exp_q[$];

  always #4 clk_i = ~clk_i;

  gpio_pin_cell u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .par_out_i(par_out_i),
    .par_in_o(par_in_o), .pad_in_i(pad_in_i), .pad_oe_o(pad_oe_o),
    .pad_out_o(pad_out_o), .func_sel_o(func_sel_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] probe(input int p);
    case (p)
      P_RD:    probe = rdata_o;
      P_IRQ:   probe = {31'b0, irq_o};
      P_OE:    probe = {31'b0, pad_oe_o};
      P_OUT:   probe = {31'b0, pad_out_o};
      P_PIN:   probe = {31'b0, par_in_o};
      default: probe = {29'b0, func_sel_o};
    endcase
  endfunction

  // monitor: compares queued items one step after the falling edge
  always @(negedge clk_i) begin
    #1;
    while (tag_q.size() > 0) begin
      automatic string       t = tag_q.pop_front();
      automatic int          p = prb_q.pop_front();
      automatic logic [31:0] e = exp_q.pop_front();
      automatic logic [31:0] a = probe(p);
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s probe %0d actual 0x%08h expected 0x%08h", t, p, a, e);
      end
    end
  end

  task automatic push(input string t, input int p, input logic [31:0] e);
    tag_q.push_back(t); prb_q.push_back(p); exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    step(1);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    addr_i = a;
    push(t, P_RD, e);
  endtask

  task automatic clr_stat();
    wr(2'd2, 32'h1);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, 32'h0000_8040, "R1 ctrl");
    push("R1 irq", P_IRQ, 0);
    push("R1 oe", P_OE, 0);
    push("R6 pad off at reset", P_PIN, 0);
    step(1);
    rd(2'd1, 0, "R1 lock");
    step(1);
    rd(2'd2, 0, "R1 stat");
    step(1);

    // R2 mask
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0001_FFFF, "R2 mask");
    push("R5 func sel", P_FN, 7);
    push("R5 func forces oe", P_OE, 0);
    step(1);
    // R10 pad enable while level moves
    wr(2'd0, 32'h0000_0043);
    step(2);
    push("R10 enable no edge", P_IRQ, 0);
    rd(2'd0, 32'h0100_0043, "R2 R6 live bit");
    push("R6 par in", P_PIN, 1);
    step(1);

    // R3 R5 output paths
    wr(2'd0, 32'h0001_0243);
    push("R5 pp oe", P_OE, 1);
    push("R3 ctrl val 1", P_OUT, 1);
    step(1);
    wr(2'd0, 32'h0000_0243);
    push("R3 ctrl val 0", P_OUT, 0);
    step(1);
    wr(2'd0, 32'h0000_0643);
    par_out_i = 1'b1;
    push("R3 par src 1", P_OUT, 1);
    step(1);
    par_out_i = 1'b0;
    push("R3 par src 0", P_OUT, 0);
    step(1);
    wr(2'd0, 32'h0000_0E43);
    push("R4 invert", P_OUT, 1);
    step(1);
    wr(2'd0, 32'h0001_0343);
    push("R5 od high no oe", P_OE, 0);
    step(1);
    wr(2'd0, 32'h0000_0343);
    push("R5 od low oe", P_OE, 1);
    push("R5 od low out", P_OUT, 0);
    step(1);
    wr(2'd0, 32'h0000_0043);
    push("R5 input no oe", P_OE, 0);
    step(1);

    // R6 pad disable and latency
    wr(2'd0, 32'h0000_8043);
    push("R6 off gates", P_PIN, 0);
    rd(2'd0, 32'h0000_8043, "R6 off bit24");
    step(1);
    wr(2'd0, 32'h0000_0043);
    step(2);
    pad_in_i = 1'b0;
    step(1);
    push("R6 latency 1", P_PIN, 1);
    step(1);
    push("R6 latency 2", P_PIN, 0);
    step(1);

    // R7 low level
    wr(2'd0, 32'h0000_0003);
    push("R7 low not yet", P_IRQ, 0);
    step(1);
    push("R7 low set", P_IRQ, 1);
    step(1);
    clr_stat();
    push("R7 low holds", P_IRQ, 1);
    step(1);
    wr(2'd0, 32'h0000_0043);
    clr_stat();
    push("R8 clear", P_IRQ, 0);
    step(1);
    // R7 high level
    pad_in_i = 1'b1;
    step(2);
    wr(2'd0, 32'h0000_0013);
    push("R7 high not yet", P_IRQ, 0);
    step(1);
    push("R7 high set", P_IRQ, 1);
    pad_in_i = 1'b0;
    step(3);
    clr_stat();
    push("R7 clear after level gone", P_IRQ, 0);
    wr(2'd0, 32'h0000_0043);

    // R8 rising
    wr(2'd0, 32'h0000_00D3);
    step(2);
    push("R10 rise arm", P_IRQ, 0);
    pad_in_i = 1'b1;
    step(2);
    push("R8 rise latency", P_IRQ, 0);
    step(1);
    push("R8 rise set", P_IRQ, 1);
    clr_stat();
    push("R8 rise clr", P_IRQ, 0);
    pad_in_i = 1'b0;
    step(4);
    push("R8 rise ignores fall", P_IRQ, 0);
    // falling
    wr(2'd0, 32'h0000_00E3);
    pad_in_i = 1'b1;
    step(4);
    push("R8 fall ignores rise", P_IRQ, 0);
    pad_in_i = 1'b0;
    step(3);
    push("R8 fall set", P_IRQ, 1);
    clr_stat();
    // both
    wr(2'd0, 32'h0000_00F3);
    pad_in_i = 1'b1;
    step(3);
    push("R8 both rise", P_IRQ, 1);
    clr_stat();
    push("R8 both clr", P_IRQ, 0);
    pad_in_i = 1'b0;
    step(3);
    push("R8 both fall", P_IRQ, 1);
    clr_stat();

    // R9 unlisted and off codes
    wr(2'd0, 32'h0000_0023);
    pad_in_i = 1'b1;
    step(3);
    pad_in_i = 1'b0;
    step(3);
    push("R9 code 2", P_IRQ, 0);
    wr(2'd0, 32'h0000_0073);
    pad_in_i = 1'b1;
    step(3);
    push("R9 code 7", P_IRQ, 0);
    wr(2'd0, 32'h0000_0043);
    pad_in_i = 1'b0;
    step(3);
    push("R9 code 4", P_IRQ, 0);

    // R10 mode and pad enable change together with level jump
    pad_in_i = 1'b1;
    wr(2'd0, 32'h0000_8043);
    step(2);
    wr(2'd0, 32'h0000_00D3);
    step(3);
    push("R10 no false edge", P_IRQ, 0);
    step(1);

    // R11 lock
    wr(2'd0, 32'h0001_0243);
    wr(2'd1, 32'h1);
    rd(2'd1, 1, "R11 lock set");
    step(1);
    wr(2'd0, 32'h0000_0043);
    rd(2'd0, 32'h0101_0243, "R11 ctrl frozen");
    push("R11 oe kept", P_OE, 1);
    push("R11 out kept", P_OUT, 1);
    step(1);
    wr(2'd1, 32'h0);
    rd(2'd1, 1, "R11 lock sticks");
    step(1);
    rst_ni = 1'b0;
    step(1);
    rst_ni = 1'b1;
    rd(2'd1, 0, "R11 reset clears lock");
    step(1);
    rd(2'd0, 32'h0000_8040, "R1 ctrl after reset");
    step(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule